// File: doc/BRIEF.md
# PS/2 Host Receive Port with Guarded Abort

This block sits on the host side of a PS/2 keyboard link. It drives two open-drain lines, clock and data, and it reads them back. It takes in 11-bit frames from the device. Each frame holds a start bit of 0, then eight data bits with the least significant bit first, then an odd-parity bit and a stop bit of 1. A good byte goes into a one-entry buffer. The block shows that buffer as a valid/ready stream. A plain 4-bit output shows how many frame bits have arrived so far in the frame in progress.

Host software controls the block through three plain pins:

- An enable level.
- A clock-inhibit request, which holds the clock line low.
- A start-bit pulse.

The inhibit request aborts a reception. The block accepts it only while the bit count is below 9. From count 9 onward the parity bit is arriving, and the request waits until the stop bit has been taken. To begin a host-to-device transfer, software inhibits the clock and drives the start bit with data held low. It then releases the clock. At that point the byte serialiser outside this block takes over. Software returns the block to reception by raising enable again and releasing the inhibit.

Back-pressure works as follows. `rx_valid` stays high, and `rx_data` does not change, until a cycle in which `rx_ready` is also high. If a good frame completes while `rx_valid` is already high, that frame is dropped. The byte in the buffer is kept.

Top module: `ps2_host_port`

## Requirements
- R1: After reset both line enables are low, `rx_valid` is 0, `rx_err` is 0, `tx_active` is 0 and `rx_count` is 0.
- R2: A frame made of a 0 start bit, eight data bits LSB first, an odd-parity bit and a 1 stop bit raises `rx_valid` with the byte on `rx_data`. At the same time `rx_count` returns to 0.
- R3: Bits are taken on falling edges of the clock line. `rx_count` equals the number of frame bits taken so far, and it never exceeds 10.
- R4: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` stays 1 and `rx_data` stays stable. A cycle with both high clears `rx_valid`.
- R5: A frame whose nine data-plus-parity bits hold an even number of ones sets `rx_err` and leaves `rx_valid` at 0. The next good frame clears `rx_err`.
- R6: A frame whose stop bit is 0 sets `rx_err` and leaves `rx_valid` at 0.
- R7: An inhibit request made while `rx_count` is below 9 drives the clock line low and resets `rx_count` to 0. The partial frame is discarded.
- R8: An inhibit request made while `rx_count` is 9 or 10 has no effect on the clock line until the stop bit is taken. The frame is then delivered, and the inhibit takes effect afterwards.
- R9: While enable is 0, `rx_count` is held at 0 and no frame is received.
- R10: A `tx_start` pulse while the clock is inhibited drives the data line low. Releasing the inhibit then releases the clock with data still low, and `tx_active` goes to 1.
- R11: A rising edge of enable releases the data line, and reception resumes.
- R12: A good frame that completes while `rx_valid` is 1 is dropped, and `rx_data` keeps the earlier byte.
- R13: A falling clock edge that finds the data line high while `rx_count` is 0 is not taken as a start bit, so `rx_count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receive enable level; low flushes the bit count |
| inhibit_req | input | 1 | Clock-inhibit (abort) request level |
| tx_start | input | 1 | Pulse: drive the start bit while inhibited |
| ps2_clk_i | input | 1 | Sensed level of the clock line |
| ps2_dat_i | input | 1 | Sensed level of the data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| rx_valid | output | 1 | Buffer holds a received byte (buffer full) |
| rx_ready | input | 1 | Consumer accepts the byte |
| rx_data | output | DATA_W | Received byte |
| rx_err | output | 1 | Last completed frame had a bad parity or stop bit |
| rx_count | output | CNT_W | Frame bits taken so far |
| tx_active | output | 1 | Start bit is driven and the clock is released |

## Verification
The hardest case is an inhibit request that arrives with exactly nine bits counted. A design that compares against the wrong threshold would pull the clock low in the middle of the parity bit and lose the byte. The bench therefore pairs that case with a request made at four bits, which must abort the frame.

Frames with bad parity and frames with a zero stop bit check that a faulty frame never raises `rx_valid`. A frame that arrives while the buffer is held full checks that the stored byte is not overwritten. The bench also checks that a high data level on the first clock edge does not start the count, and that disabling the block clears the count. Finally, the transmit handoff order is checked: data low first, then the clock released, then the data line freed when enable returns.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
  typedef enum logic [1:0] {
    LINE_LISTEN  = 2'd0,
    LINE_HOLD    = 2'd1,
    LINE_HANDOFF = 2'd2,
    LINE_PRIMED  = 2'd3
  } line_mode_e;

  function automatic int frame_len(input int data_w);
    return data_w + 3;
  endfunction
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic dat_line,
  output logic dat_sync,
  output logic clk_fall
);
  logic [1:0] chain [STAGES];
  logic       clk_prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= {dat_line, clk_line};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= chain[STAGES-1][0];
  end

  assign dat_sync = chain[STAGES-1][1];
  assign clk_fall = clk_prev & ~chain[STAGES-1][0];
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(ps2_host_pkg::frame_len(DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  count,
  output logic              done,
  output logic              good,
  output logic [DATA_W-1:0] data
);
  localparam int PAR_IDX  = DATA_W + 1;
  localparam int STOP_IDX = DATA_W + 2;

  logic [DATA_W-1:0] shreg;
  logic              par_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      good    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (flush) begin
        count <= '0;
      end else if (take) begin
        if (count == '0) begin
          if (!bit_in) count <= CNT_W'(1);
        end else if (count <= CNT_W'(DATA_W)) begin
          shreg <= {bit_in, shreg[DATA_W-1:1]};
          count <= count + CNT_W'(1);
        end else if (count == CNT_W'(PAR_IDX)) begin
          par_bit <= bit_in;
          count   <= count + CNT_W'(1);
        end else if (count == CNT_W'(STOP_IDX)) begin
          done  <= 1'b1;
          good  <= bit_in & ((^shreg) ^ par_bit);
          count <= '0;
        end
      end
    end
  end

  assign data = shreg;
endmodule

// File: rtl/ps2_line_ctrl.sv
module ps2_line_ctrl #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(ps2_host_pkg::frame_len(DATA_W))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    inhibit_req,
  input  logic                    tx_start,
  input  logic [CNT_W-1:0]        count,
  output ps2_host_pkg::line_mode_e mode,
  output logic                    clk_oe,
  output logic                    dat_oe,
  output logic                    rx_allow
);
  import ps2_host_pkg::*;
  localparam int PAR_IDX = DATA_W + 1;

  logic inhibit_q;
  logic start_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit_q <= 1'b0;
      start_q   <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      en_q <= en;
      if (!inhibit_req)
        inhibit_q <= 1'b0;
      else if (!inhibit_q && count < CNT_W'(PAR_IDX))
        inhibit_q <= 1'b1;

      if (en && !en_q)
        start_q <= 1'b0;
      else if (tx_start && inhibit_q && inhibit_req)
        start_q <= 1'b1;
    end
  end

  always_comb begin
    unique case ({start_q, inhibit_q})
      2'b01:   mode = LINE_HOLD;
      2'b11:   mode = LINE_PRIMED;
      2'b10:   mode = LINE_HANDOFF;
      default: mode = LINE_LISTEN;
    endcase
  end

  assign clk_oe   = inhibit_q;
  assign dat_oe   = start_q;
  assign rx_allow = en && (mode == LINE_LISTEN);
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(ps2_host_pkg::frame_len(DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inhibit_req,
  input  logic              tx_start,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_oe,
  output logic              ps2_dat_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err,
  output logic [CNT_W-1:0]  rx_count,
  output logic              tx_active
);
  import ps2_host_pkg::*;

  logic              dat_s, clk_fall;
  logic              rx_allow;
  logic              f_done, f_good;
  logic [DATA_W-1:0] f_data;
  line_mode_e        mode;

  ps2_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .clk_line(ps2_clk_i), .dat_line(ps2_dat_i),
    .dat_sync(dat_s), .clk_fall(clk_fall)
  );

  ps2_line_ctrl #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .en(en),
    .inhibit_req(inhibit_req), .tx_start(tx_start),
    .count(rx_count), .mode(mode),
    .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe), .rx_allow(rx_allow)
  );

  ps2_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .flush(!rx_allow), .take(clk_fall), .bit_in(dat_s),
    .count(rx_count), .done(f_done), .good(f_good), .data(f_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (f_done) begin
        if (f_good) begin
          rx_err <= 1'b0;
          if (!rx_valid) begin
            rx_valid <= 1'b1;
            rx_data  <= f_data;
          end
        end else begin
          rx_err <= 1'b1;
        end
      end
    end
  end

  assign tx_active = (mode == LINE_HANDOFF);
endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(ps2_host_pkg::frame_len(DATA_W))
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ps2_clk_oe,
  input logic              ps2_dat_oe,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic [CNT_W-1:0]  rx_count
);
  localparam int PAR_IDX  = DATA_W + 1;
  localparam int STOP_IDX = DATA_W + 2;

  assert_done_clears_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> rx_count == '0);

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(STOP_IDX));

  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  assert_abort_below_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_clk_oe) |-> $past(rx_count) < CNT_W'(PAR_IDX));

  assert_disable_flushes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> rx_count == '0);

  assert_start_while_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_dat_oe) |-> ps2_clk_oe);
endmodule

bind ps2_host_port ps2_host_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_count(rx_count)
);

// File: tb/test_ps2_host_port.sv
module test_ps2_host_port;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, inhibit_req = 1'b0, tx_start = 1'b0, rx_ready = 1'b0;
  logic dev_clk_low = 1'b0, dev_dat_low = 1'b0;
  logic ps2_clk_line, ps2_dat_line;
  logic ps2_clk_oe, ps2_dat_oe, rx_valid, rx_err, tx_active;
  logic [7:0] rx_data;
  logic [3:0] rx_count;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign ps2_clk_line = !(dev_clk_low || ps2_clk_oe);
  assign ps2_dat_line = !(dev_dat_low || ps2_dat_oe);

  ps2_host_port i_ps2_host_port (
    .clk(clk), .rst_n(rst_n), .en(en), .inhibit_req(inhibit_req),
    .tx_start(tx_start), .ps2_clk_i(ps2_clk_line), .ps2_dat_i(ps2_dat_line),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .rx_count(rx_count), .tx_active(tx_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dev_bit(input logic b);
    dev_dat_low = !b;
    idle(H);
    dev_clk_low = 1'b1;
    idle(H);
    dev_clk_low = 1'b0;
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] d, input bit par_ok, input bit stop);
    logic p = ~^d;
    if (!par_ok) p = ~p;
    return {stop, p, d, 1'b0};
  endfunction

  task automatic send_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) dev_bit(f[i]);
    dev_dat_low = 1'b0;
    idle(10);
  endtask

  task automatic consume();
    rx_ready = 1'b1;
    idle(1);
    rx_ready = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 clk_oe", ps2_clk_oe, 0);
    chk("R1 dat_oe", ps2_dat_oe, 0);
    chk("R1 valid", rx_valid, 0);
    chk("R1 err", rx_err, 0);
    chk("R1 tx_active", tx_active, 0);
    chk("R1 count", rx_count, 0);
  endtask

  task automatic t_good(input logic [7:0] d);
    send_bits(mk_frame(d, 1, 1), 11);
    chk("R2 valid", rx_valid, 1);
    chk("R2 data", rx_data, d);
    chk("R2 count", rx_count, 0);
    consume();
    chk("R4 cleared", rx_valid, 0);
  endtask

  task automatic t_count();
    logic [10:0] f = mk_frame(8'h96, 1, 1);
    for (int i = 0; i < 4; i++) dev_bit(f[i]);
    idle(10);
    chk("R3 count4", rx_count, 4);
    for (int i = 4; i < 11; i++) dev_bit(f[i]);
    dev_dat_low = 1'b0;
    idle(10);
    chk("R3 data", rx_data, 8'h96);
    consume();
  endtask

  task automatic t_hold();
    send_bits(mk_frame(8'hC3, 1, 1), 11);
    idle(200);
    chk("R4 held valid", rx_valid, 1);
    chk("R4 held data", rx_data, 8'hC3);
    consume();
    chk("R4 released", rx_valid, 0);
  endtask

  task automatic t_overrun();
    send_bits(mk_frame(8'h11, 1, 1), 11);
    send_bits(mk_frame(8'h22, 1, 1), 11);
    chk("R12 valid", rx_valid, 1);
    chk("R12 kept", rx_data, 8'h11);
    consume();
    chk("R12 dropped", rx_valid, 0);
  endtask

  task automatic t_parity();
    send_bits(mk_frame(8'h5A, 0, 1), 11);
    chk("R5 err", rx_err, 1);
    chk("R5 no valid", rx_valid, 0);
    send_bits(mk_frame(8'h5A, 1, 1), 11);
    chk("R5 err cleared", rx_err, 0);
    consume();
  endtask

  task automatic t_stop();
    send_bits(mk_frame(8'h0F, 1, 0), 11);
    chk("R6 err", rx_err, 1);
    chk("R6 no valid", rx_valid, 0);
    chk("R6 count", rx_count, 0);
  endtask

  task automatic t_abort();
    send_bits(mk_frame(8'hE7, 1, 1), 4);
    chk("R7 pre count", rx_count, 4);
    inhibit_req = 1'b1;
    idle(5);
    chk("R7 clk held", ps2_clk_oe, 1);
    chk("R7 count flushed", rx_count, 0);
    inhibit_req = 1'b0;
    idle(10);
    chk("R7 released", ps2_clk_oe, 0);
    chk("R7 no valid", rx_valid, 0);
  endtask

  task automatic t_refuse();
    logic [10:0] f = mk_frame(8'h3C, 1, 1);
    for (int i = 0; i < 9; i++) dev_bit(f[i]);
    idle(10);
    chk("R8 count9", rx_count, 9);
    inhibit_req = 1'b1;
    idle(5);
    chk("R8 clk free", ps2_clk_oe, 0);
    chk("R8 count kept", rx_count, 9);
    dev_bit(f[9]);
    dev_bit(f[10]);
    dev_dat_low = 1'b0;
    idle(10);
    chk("R8 valid", rx_valid, 1);
    chk("R8 data", rx_data, 8'h3C);
    chk("R8 late inhibit", ps2_clk_oe, 1);
    inhibit_req = 1'b0;
    idle(10);
    consume();
  endtask

  task automatic t_disable();
    en = 1'b0;
    idle(4);
    send_bits(mk_frame(8'h81, 1, 1), 11);
    chk("R9 count", rx_count, 0);
    chk("R9 no valid", rx_valid, 0);
    en = 1'b1;
    idle(4);
  endtask

  task automatic t_badstart();
    dev_bit(1'b1);
    idle(10);
    chk("R13 count", rx_count, 0);
  endtask

  task automatic t_tx();
    inhibit_req = 1'b1;
    idle(5);
    chk("R10 inhibit", ps2_clk_oe, 1);
    en = 1'b0;
    idle(2);
    tx_start = 1'b1;
    idle(1);
    tx_start = 1'b0;
    idle(3);
    chk("R10 data low", ps2_dat_oe, 1);
    chk("R10 not yet", tx_active, 0);
    inhibit_req = 1'b0;
    idle(3);
    chk("R10 clk released", ps2_clk_oe, 0);
    chk("R10 data still low", ps2_dat_oe, 1);
    chk("R10 tx_active", tx_active, 1);
    en = 1'b1;
    idle(3);
    chk("R11 data released", ps2_dat_oe, 0);
    chk("R11 tx_active off", tx_active, 0);
    send_bits(mk_frame(8'h6B, 1, 1), 11);
    chk("R11 resumes", rx_valid, 1);
    chk("R11 data", rx_data, 8'h6B);
    consume();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    en = 1'b1;
    idle(4);
    t_good(8'hA5);
    t_good(8'h3C);
    t_good(8'h00);
    t_count();
    t_hold();
    t_overrun();
    t_parity();
    t_stop();
    t_abort();
    t_refuse();
    t_disable();
    t_badstart();
    t_tx();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule